// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Unit

This unit gives a processor core the hardware half of an atomic read-modify-write sequence on one memory word. A load-and-reserve request reads a word and remembers its word address as a live reservation. A later conditional-store request writes its data word only if that reservation is still alive. Every conditional store reports success or failure in a 4-bit condition field, which software tests to decide whether to retry the sequence.

Each request is a 32-bit instruction word, two address operands and a store-data operand, presented with a valid strobe. The unit decodes the word, forms the effective address and registers the request. One cycle later it drives the simple word memory port, a done pulse and, for conditional stores, the condition field. A snoop input reports word stores made by other agents. A snooped store to the reserved word kills the reservation, so the conditional store fails. Requests may arrive on every cycle.

Top module: `lrsc_unit`

## Requirements
- R1: With instruction bits numbered 31 (most significant) down to 0, a word is a conditional store when bits 31:26 equal 31, bits 10:1 equal 150 and bit 0 is 1. It is a load-and-reserve when bits 31:26 equal 31, bits 10:1 equal 20 and bit 0 is 0. Any other word, or any cycle without `req_valid`, gives no `done` and no memory access. A decoded request gives `done` exactly one cycle after it is accepted.
- R2: The effective address, driven on `mem_addr` during the `done` cycle, is `opnd_b` when the register field in bits 20:16 is zero and `opnd_a + opnd_b` otherwise.
- R3: A conditional store with a live reservation raises `mem_wr_en` with `mem_wdata = opnd_s` and reports `cr_field` bits 3:1 = 001.
- R4: A conditional store without a live reservation leaves memory untouched (`mem_wr_en` low) and reports `cr_field` bits 3:1 = 000.
- R5: `cr_field` bit 0 carries the `so_in` value that was sampled with the conditional store, on both success and failure. `cr_we` is high only in the done cycle of a conditional store.
- R6: A load-and-reserve raises `mem_rd_en` in its done cycle, returns `mem_rdata` on `ld_data` and sets the reservation to its word address. This replaces any earlier reservation.
- R7: A snoop (`snoop_valid`) whose word address equals the reserved word clears the reservation. A snoop to a different word leaves it intact.
- R8: A matching snoop in the same cycle as a conditional store's done cycle makes that store fail. A matching snoop in a load-and-reserve's done cycle leaves no reservation.
- R9: Every conditional store clears the reservation, whether it succeeds or fails, so a second conditional store without a new load-and-reserve fails.
- R10: After synchronous reset there is no reservation, and `done`, `mem_wr_en` and `mem_rd_en` are low.
- R11: `misaligned` is high in a done cycle whose effective address has nonzero bits 1:0. The store decision does not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_instr | input | 32 | Instruction word of the request |
| opnd_a | input | 32 | Address operand selected by bits 20:16 |
| opnd_b | input | 32 | Second address operand |
| opnd_s | input | 32 | Store data operand |
| so_in | input | 1 | Overflow-summary flag sampled with the request |
| snoop_valid | input | 1 | Another agent stores a word |
| snoop_word | input | 30 | Word address of that foreign store |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, combinational from mem_addr |
| done | output | 1 | Request completion pulse |
| cr_we | output | 1 | Condition field valid |
| cr_field | output | 4 | Condition result {lt, gt, eq, so} |
| ld_data | output | 32 | Loaded word |
| misaligned | output | 1 | Effective address not word aligned |

## Verification
Directed sequences cover several cases: a store right after reset, a load-reserve followed by a store, a repeated store, snoops to the reserved word and to other words at each pipeline position, a second reservation that replaces the first, and malformed instruction words. Together these separate the reservation-held, reservation-lost and no-request outcomes. Both address forms and unaligned addresses separate the two effective-address rules from the alignment flag. A long pseudo-random mix of back-to-back requests, bad words and snoops is then compared cycle by cycle against a behavioural model. This exposes ordering errors between a snoop and a reservation that is being set or consumed in the same cycle.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int unsigned INSN_W = 32;
    localparam logic [5:0]  PRIMARY_OP    = 6'd31;
    localparam logic [9:0]  XO_STORE_COND = 10'd150;
    localparam logic [9:0]  XO_LOAD_RES   = 10'd20;

    typedef enum logic [1:0] {
        KIND_NONE       = 2'd0,
        KIND_LOAD_RES   = 2'd1,
        KIND_STORE_COND = 2'd2
    } req_kind_e;

    typedef struct packed {
        req_kind_e kind;
        logic      base_is_zero;
    } decode_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    function automatic decode_t decode_word(input logic [INSN_W-1:0] w);
        decode_t d;
        d.base_is_zero = (w[20:16] == 5'd0);
        if (w[31:26] == PRIMARY_OP && w[10:1] == XO_STORE_COND && w[0])
            d.kind = KIND_STORE_COND;
        else if (w[31:26] == PRIMARY_OP && w[10:1] == XO_LOAD_RES && !w[0])
            d.kind = KIND_LOAD_RES;
        else
            d.kind = KIND_NONE;
        return d;
    endfunction

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [INSN_W-1:0] instr,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    output req_kind_e         kind,
    output logic [XLEN-1:0]   eff_addr
);

    decode_t dec;

    always_comb begin
        dec      = decode_word(instr);
        kind     = dec.kind;
        eff_addr = dec.base_is_zero ? opnd_b : (opnd_a + opnd_b);
    end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
    parameter int unsigned WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [WORD_W-1:0] set_word,
    input  logic              clr_en,
    input  logic              snoop_valid,
    input  logic [WORD_W-1:0] snoop_word,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_word,
    output logic              live
);

    logic hit_held;
    logic hit_new;

    always_comb begin
        hit_held = snoop_valid && (snoop_word == res_word);
        hit_new  = snoop_valid && (snoop_word == set_word);
        live     = res_valid && !hit_held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_word  <= '0;
        end else if (set_en) begin
            res_valid <= !hit_new;
            res_word  <= set_word;
        end else if (clr_en || hit_held) begin
            res_valid <= 1'b0;
        end
    end

    AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !res_valid); // R9

    AST_SNOOP_KILLS_RESV: assert property (@(posedge clk) disable iff (rst)
        (!set_en && snoop_valid && snoop_word == res_word) |=> !res_valid); // R7

    AST_LR_TAKES_WORD: assert property (@(posedge clk) disable iff (rst)
        (set_en && !(snoop_valid && snoop_word == set_word))
        |=> (res_valid && res_word == $past(set_word))); // R6

endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [INSN_W-1:0] req_instr,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [XLEN-1:0]   opnd_s,
    input  logic              so_in,
    input  logic              snoop_valid,
    input  logic [XLEN-3:0]   snoop_word,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              done,
    output logic              cr_we,
    output logic [3:0]        cr_field,
    output logic [XLEN-1:0]   ld_data,
    output logic              misaligned
);

    localparam int unsigned WORD_W = XLEN - 2;

    typedef struct packed {
        logic            valid;
        req_kind_e       kind;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] data;
        logic            so;
    } stage_t;

    req_kind_e       dec_kind;
    logic [XLEN-1:0] dec_addr;
    stage_t          stg;
    logic            is_sc;
    logic            is_lr;
    logic            res_valid;
    logic [WORD_W-1:0] res_word;
    logic            live;
    cond_t           cond;

    lrsc_decode #(.XLEN(XLEN)) u_decode (
        .instr    (req_instr),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .kind     (dec_kind),
        .eff_addr (dec_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg.valid <= req_valid && (dec_kind != KIND_NONE);
            stg.kind  <= dec_kind;
            stg.addr  <= dec_addr;
            stg.data  <= opnd_s;
            stg.so    <= so_in;
        end
    end

    always_comb begin
        is_sc = stg.valid && (stg.kind == KIND_STORE_COND);
        is_lr = stg.valid && (stg.kind == KIND_LOAD_RES);
    end

    lrsc_resv #(.WORD_W(WORD_W)) u_resv (
        .clk         (clk),
        .rst         (rst),
        .set_en      (is_lr),
        .set_word    (stg.addr[XLEN-1:2]),
        .clr_en      (is_sc),
        .snoop_valid (snoop_valid),
        .snoop_word  (snoop_word),
        .res_valid   (res_valid),
        .res_word    (res_word),
        .live        (live)
    );

    always_comb begin
        cond.lt    = 1'b0;
        cond.gt    = 1'b0;
        cond.eq    = is_sc && live;
        cond.so    = stg.so;
        mem_wr_en  = is_sc && live;
        mem_rd_en  = is_lr;
        mem_addr   = stg.addr;
        mem_wdata  = stg.data;
        done       = stg.valid;
        cr_we      = is_sc;
        cr_field   = cr_we ? cond : 4'b0000;
        ld_data    = is_lr ? mem_rdata : '0;
        misaligned = stg.valid && (stg.addr[1:0] != 2'b00);
    end

    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req_valid)); // R1

    AST_WRITE_NEEDS_RESV: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (res_valid && cr_we)); // R4

    AST_SNOOP_BEATS_STORE: assert property (@(posedge clk) disable iff (rst)
        (cr_we && snoop_valid && snoop_word == res_word) |-> !mem_wr_en); // R8

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_en && mem_rd_en)); // R3

endmodule

// File: tb/lrsc_unit_bench.sv
module lrsc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_instr = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, opnd_s = '0;
    logic        so_in = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [29:0] snoop_word = '0;
    logic        mem_rd_en, mem_wr_en, done, cr_we, misaligned;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
    logic [3:0]  cr_field;

    logic [31:0] bmem [16];
    logic [31:0] rmem [16];

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // model state
    bit          m_pv;
    int          m_kind;
    logic [31:0] m_ea, m_s;
    bit          m_so;
    bit          m_rv;
    logic [29:0] m_rw;

    always #10 clk = ~clk;

    assign mem_rdata = bmem[mem_addr[5:2]];

    lrsc_unit u_lrsc_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_instr(req_instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_s(opnd_s), .so_in(so_in),
        .snoop_valid(snoop_valid), .snoop_word(snoop_word),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .cr_we(cr_we), .cr_field(cr_field), .ld_data(ld_data),
        .misaligned(misaligned)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_wr_en) bmem[mem_addr[5:2]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int kind_of(input logic [31:0] w);
        if (w[31:26] == 6'd31 && w[10:1] == 10'd150 && w[0] == 1'b1) return 2;
        if (w[31:26] == 6'd31 && w[10:1] == 10'd20 && w[0] == 1'b0) return 1;
        return 0;
    endfunction

    // reference model, evaluated mid-cycle with the inputs of that cycle
    always @(negedge clk) begin
        if (rst) begin
            m_pv = 0;
            m_rv = 0;
        end else begin
            bit hit_held, hit_new, e_wr, e_lr, e_sc;
            e_sc = m_pv && m_kind == 2;
            e_lr = m_pv && m_kind == 1;
            hit_held = snoop_valid && snoop_word == m_rw;
            hit_new = snoop_valid && snoop_word == m_ea[31:2];
            e_wr = e_sc && m_rv && !hit_held;
            chk(done == m_pv, "R1 done", {31'd0, done}, {31'd0, m_pv});
            chk(mem_rd_en == e_lr, "R6 mem_rd_en", {31'd0, mem_rd_en}, {31'd0, e_lr});
            chk(mem_wr_en == e_wr, "R3/R4/R7/R8/R9 mem_wr_en", {31'd0, mem_wr_en}, {31'd0, e_wr});
            chk(cr_we == e_sc, "R5 cr_we", {31'd0, cr_we}, {31'd0, e_sc});
            if (m_pv) begin
                chk(mem_addr == m_ea, "R2 mem_addr", mem_addr, m_ea);
                chk(misaligned == (m_ea[1:0] != 0), "R11 misaligned",
                    {31'd0, misaligned}, {31'd0, m_ea[1:0] != 0});
            end
            if (e_sc)
                chk(cr_field == {2'b00, e_wr, m_so}, "R3/R4/R5 cr_field",
                    {28'd0, cr_field}, {28'd0, 2'b00, e_wr, m_so});
            if (e_wr) begin
                chk(mem_wdata == m_s, "R3 mem_wdata", mem_wdata, m_s);
                rmem[m_ea[5:2]] = m_s;
            end
            if (e_lr) chk(ld_data == rmem[m_ea[5:2]], "R6 ld_data", ld_data, rmem[m_ea[5:2]]);
            // next state
            if (e_lr) begin
                m_rv = !hit_new;
                m_rw = m_ea[31:2];
            end else if (e_sc || hit_held) begin
                m_rv = 0;
            end
            m_pv = req_valid && kind_of(req_instr) != 0;
            m_kind = kind_of(req_instr);
            m_ea = (req_instr[20:16] == 0) ? opnd_b : opnd_a + opnd_b;
            m_s = opnd_s;
            m_so = so_in;
        end
    end

    function automatic logic [31:0] sc_w(input logic [4:0] ra);
        return {6'd31, 5'd4, ra, 5'd3, 10'd150, 1'b1};
    endfunction
    function automatic logic [31:0] lr_w(input logic [4:0] ra);
        return {6'd31, 5'd5, ra, 5'd3, 10'd20, 1'b0};
    endfunction

    task automatic step(input bit v, input logic [31:0] w, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] s, input bit so,
                        input bit sv, input logic [29:0] sw);
        req_valid = v; req_instr = w; opnd_a = a; opnd_b = b; opnd_s = s;
        so_in = so; snoop_valid = sv; snoop_word = sw;
        @(posedge clk);
        #2;
        req_valid = 0; snoop_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 32'd0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            bmem[i] = 32'h1000_0000 + i;
            rmem[i] = 32'h1000_0000 + i;
        end
        repeat (3) @(posedge clk);
        #2;
        rst = 0;
        @(negedge clk);
        chk(done == 0 && mem_wr_en == 0 && mem_rd_en == 0, "R10 reset outputs",
            {29'd0, done, mem_wr_en, mem_rd_en}, 32'd0);
        @(posedge clk); #2;
        // R10: store straight after reset fails
        step(1, sc_w(0), 0, 32'h10, 32'hAAAA_0001, 0, 0, 0); idle(2);
        // R3 success, base-zero form (R2)
        step(1, lr_w(0), 32'h7, 32'h20, 0, 0, 0, 0); idle(1);
        step(1, sc_w(0), 0, 32'h20, 32'hBEEF_0002, 0, 0, 0); idle(1);
        // R9 repeat fails
        step(1, sc_w(0), 0, 32'h20, 32'hDEAD_0003, 1, 0, 0); idle(1);
        step(1, lr_w(0), 0, 32'h20, 0, 0, 0, 0); idle(2);
        // R2 sum form, R7 non-matching snoop keeps reservation
        step(1, lr_w(5'd2), 32'h8, 32'h4, 0, 0, 0, 0); idle(1);
        step(0, 0, 0, 0, 0, 0, 1, 30'h5);
        step(1, sc_w(5'd2), 32'h8, 32'h4, 32'h1234_0004, 1, 0, 0); idle(2);
        // R7 matching snoop kills reservation
        step(1, lr_w(0), 0, 32'h14, 0, 0, 0, 0); idle(1);
        step(0, 0, 0, 0, 0, 0, 1, 30'h5);
        step(1, sc_w(0), 0, 32'h14, 32'h5555_0005, 0, 0, 0); idle(2);
        // R8 snoop in store's done cycle
        step(1, lr_w(0), 0, 32'h18, 0, 0, 0, 0); idle(1);
        step(1, sc_w(0), 0, 32'h18, 32'h6666_0006, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 30'h6); idle(1);
        // R8 snoop in load-reserve done cycle
        step(1, lr_w(0), 0, 32'h1C, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 30'h7);
        step(1, sc_w(0), 0, 32'h1C, 32'h7777_0007, 0, 0, 0); idle(2);
        // R6 replacement: snoop to old word does not matter
        step(1, lr_w(0), 0, 32'h24, 0, 0, 0, 0);
        step(1, lr_w(0), 0, 32'h28, 0, 0, 0, 0); idle(1);
        step(0, 0, 0, 0, 0, 0, 1, 30'h9);
        step(1, sc_w(0), 0, 32'h28, 32'h8888_0008, 1, 0, 0); idle(2);
        // R1 malformed words give no done
        step(1, lr_w(0), 0, 32'h2C, 0, 0, 0, 0); idle(1);
        step(1, sc_w(0) & ~32'd1, 0, 32'h2C, 32'h9, 0, 0, 0);
        step(1, sc_w(0) ^ 32'h0400_0000, 0, 32'h2C, 32'h9, 0, 0, 0);
        step(1, sc_w(0) ^ 32'h0000_0004, 0, 32'h2C, 32'h9, 0, 0, 0);
        step(1, sc_w(0), 0, 32'h2C, 32'h9999_0009, 0, 0, 0); idle(2);
        // R11 misaligned
        step(1, lr_w(0), 0, 32'h31, 0, 0, 0, 0); idle(1);
        step(1, sc_w(0), 0, 32'h31, 32'hABCD_000A, 0, 0, 0); idle(2);
        // back-to-back then random mix
        step(1, lr_w(0), 0, 32'h30, 0, 0, 0, 0);
        step(1, sc_w(0), 0, 32'h30, 32'hCAFE_000B, 1, 0, 0); idle(2);
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [4:0] ra;
            logic [31:0] w;
            op = $urandom % 5;
            ra = 5'($urandom % 3);
            case (op)
                0, 1: w = lr_w(ra);
                2, 3: w = sc_w(ra);
                default: w = sc_w(ra) ^ 32'h0000_0002;
            endcase
            step(($urandom % 3) != 0, w, ($urandom % 16) & ~32'd3, ($urandom % 32) & ~32'd3,
                 $urandom, 1'($urandom), ($urandom % 3) == 0, 30'($urandom % 8));
        end
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule